// File: doc/BRIEF.md
# Flash Data-Polling Status Generator

This block forms the 8-bit status byte that a NOR-style flash controller returns on its data bus while an embedded buffer-program operation is held in write-buffer-abort error. While the error flag is high, every read gets this byte in place of array data, whatever address is used. When the flag is low, the block passes array data through.

The byte has several parts. One bit is the inverse of the most significant data bit of the last word written into the write buffer. Another is a toggle bit that flips on every read. A fixed pattern marks the abort. A suspend flag shows that an erase was suspended before the buffer program began. A second toggle bit flips only on reads that hit the suspended sector. The read sector is the read address shifted right by a parameter that sets the sector-size boundary.

All outputs are registered. The toggle state changes on the rising edge of a read strobe that is synchronous to the clock. The toggle state is cleared whenever the error flag is low, so each new error episode starts from zero.

Top module: `poll_status_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `dq_o` becomes 0x00 after that edge.
- R2: When `abort_err_i` is low at an edge, `dq_o` equals `array_data_i` after that edge. When it is high, `array_data_i` has no effect on `dq_o`.
- R3: In the error state, `dq_o[7]` equals the inverse of `prog_dq7_i` from the previous edge.
- R4: In the error state, `dq_o[6]` takes the values 0, 1, 0, … on the 1st, 2nd, 3rd, … read after the edge where each read is detected. The read address has no effect on this sequence.
- R5: In the error state, `dq_o[5]` is 0, `dq_o[1]` is 1, and the reserved bits `dq_o[4]` and `dq_o[0]` are driven to 0.
- R6: In the error state, `dq_o[3]` equals `ers_susp_i`.
- R7: `dq_o[2]` is 0 when no erase is suspended. With an erase suspended, it advances only on reads where `rd_addr_i >> SECT_LSB` equals `susp_sector_i`. On reads to other sectors it keeps its value.
- R8: Both toggle bits restart at 0 on every new entry into the error state.
- R9: A read is counted once, on the rising edge of `rd_stb_i`. A strobe held high for several cycles advances the toggles only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_err_i | input | 1 | Write-buffer-abort error state active |
| prog_dq7_i | input | 1 | Bit 7 of the last word loaded into the write buffer |
| ers_susp_i | input | 1 | An erase was suspended before the buffer program |
| susp_sector_i | input | ADDR_W-SECT_LSB | Number of the suspended sector |
| rd_addr_i | input | ADDR_W | Read address |
| rd_stb_i | input | 1 | Read strobe; its rising edge counts as one read |
| array_data_i | input | 8 | Array data for reads outside the error state |
| dq_o | output | 8 | Registered status byte or array data |

## Verification
Two events can land on the same clock edge: entry into the error state and the rising edge of a read strobe. A read into the suspended sector also advances both toggle bits at once. The bench raises the error flag and the strobe on the same falling edge, with the address pointing into the suspended sector. It then checks that this first read returns both toggles at 0, and that the next read returns both at 1. That shows the cleared state was used and then flipped exactly once on the shared edge.

// File: rtl/poll_pkg.sv
package poll_pkg;
  localparam int DQ_W   = 8;
  localparam int B_POLL = 7;
  localparam int B_TGL  = 6;
  localparam int B_FAIL = 5;
  localparam int B_SUSP = 3;
  localparam int B_STGL = 2;
  localparam int B_ABRT = 1;
  localparam int TGL_N  = 2;

  function automatic logic [DQ_W-1:0] abort_word(input logic dq7,
                                                 input logic t_any,
                                                 input logic susp,
                                                 input logic t_sect);
    logic [DQ_W-1:0] w;
    w         = '0;
    w[B_POLL] = ~dq7;
    w[B_TGL]  = t_any;
    w[B_FAIL] = 1'b0;
    w[B_SUSP] = susp;
    w[B_STGL] = susp & t_sect;
    w[B_ABRT] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic stb_i,
  output logic rise_o
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb_i;
  end

  assign rise_o = stb_i & ~stb_q;
endmodule

// File: rtl/sector_hit.sv
module sector_hit #(
  parameter int ADDR_W   = 16,
  parameter int SECT_LSB = 12
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [ADDR_W-SECT_LSB-1:0] sect_i,
  output logic                       hit_o
);
  localparam int SECT_W = ADDR_W - SECT_LSB;

  logic [ADDR_W-1:0] addr_sect;
  logic [ADDR_W-1:0] sect_ext;

  always_comb begin
    addr_sect = addr_i >> SECT_LSB;
    sect_ext  = '0;
    sect_ext[SECT_W-1:0] = sect_i;
    hit_o     = (addr_sect == sect_ext);
  end
endmodule

// File: rtl/toggle_bit.sv
module toggle_bit (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic adv_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst || !active_i) q_o <= 1'b0;
    else if (adv_i)       q_o <= ~q_o;
  end
endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen
  import poll_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SECT_LSB = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       abort_err_i,
  input  logic                       prog_dq7_i,
  input  logic                       ers_susp_i,
  input  logic [ADDR_W-SECT_LSB-1:0] susp_sector_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  input  logic                       rd_stb_i,
  input  logic [DQ_W-1:0]            array_data_i,
  output logic [DQ_W-1:0]            dq_o
);
  logic             rd_rise;
  logic             in_sect;
  logic [TGL_N-1:0] tgl_adv;
  logic [TGL_N-1:0] tgl_q;

  strobe_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .stb_i  (rd_stb_i),
    .rise_o (rd_rise)
  );

  sector_hit #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_hit (
    .addr_i (rd_addr_i),
    .sect_i (susp_sector_i),
    .hit_o  (in_sect)
  );

  // index 0: toggles on every read; index 1: only reads into suspended sector
  assign tgl_adv[0] = rd_rise;
  assign tgl_adv[1] = rd_rise & ers_susp_i & in_sect;

  for (genvar g = 0; g < TGL_N; g++) begin : g_tgl
    toggle_bit u_tgl (
      .clk      (clk),
      .rst      (rst),
      .active_i (abort_err_i),
      .adv_i    (tgl_adv[g]),
      .q_o      (tgl_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)              dq_o <= '0;
    else if (abort_err_i) dq_o <= abort_word(prog_dq7_i, tgl_q[0], ers_susp_i, tgl_q[1]);
    else                  dq_o <= array_data_i;
  end
endmodule

// File: rtl/poll_status_chk.sv
module poll_status_chk #(
  parameter int ADDR_W   = 16,
  parameter int SECT_LSB = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       abort_err_i,
  input logic                       prog_dq7_i,
  input logic                       ers_susp_i,
  input logic [ADDR_W-SECT_LSB-1:0] susp_sector_i,
  input logic [ADDR_W-1:0]          rd_addr_i,
  input logic                       rd_stb_i,
  input logic [7:0]                 array_data_i,
  input logic [7:0]                 dq_o,
  input logic [1:0]                 tgl_q
);
  logic [ADDR_W-1:0] a_sect;
  logic [ADDR_W-1:0] s_ext;
  logic              hit_c;

  always_comb begin
    a_sect = rd_addr_i >> SECT_LSB;
    s_ext  = '0;
    s_ext[ADDR_W-SECT_LSB-1:0] = susp_sector_i;
    hit_c  = (a_sect == s_ext);
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (dq_o == 8'h00));

  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !abort_err_i |=> (dq_o == $past(array_data_i)));

  p_msb_r3: assert property (@(posedge clk) disable iff (rst)
    abort_err_i |=> (dq_o[7] == ~$past(prog_dq7_i)));

  p_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    abort_err_i |=> (dq_o[5] == 1'b0 && dq_o[1] == 1'b1 && dq_o[4] == 1'b0 && dq_o[0] == 1'b0));

  p_susp_r6: assert property (@(posedge clk) disable iff (rst)
    abort_err_i |=> (dq_o[3] == $past(ers_susp_i)));

  p_flip_r4: assert property (@(posedge clk) disable iff (rst)
    (abort_err_i && $rose(rd_stb_i)) |=> (tgl_q[0] != $past(tgl_q[0])));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (abort_err_i && !$rose(rd_stb_i)) |=> $stable(tgl_q));

  p_sect_r7: assert property (@(posedge clk) disable iff (rst)
    (abort_err_i && !(ers_susp_i && hit_c)) |=> $stable(tgl_q[1]));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !abort_err_i |=> (tgl_q == 2'b00));
endmodule

bind poll_status_gen poll_status_chk #(.ADDR_W(ADDR_W), .SECT_LSB(SECT_LSB)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .abort_err_i   (abort_err_i),
  .prog_dq7_i    (prog_dq7_i),
  .ers_susp_i    (ers_susp_i),
  .susp_sector_i (susp_sector_i),
  .rd_addr_i     (rd_addr_i),
  .rd_stb_i      (rd_stb_i),
  .array_data_i  (array_data_i),
  .dq_o          (dq_o),
  .tgl_q         (tgl_q)
);

// File: tb/test_poll_status_gen.sv
`timescale 1ns/1ps
module test_poll_status_gen;
  localparam int AW = 16;
  localparam int SL = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          abort_err_i = 1'b0;
  logic          prog_dq7_i = 1'b0;
  logic          ers_susp_i = 1'b0;
  logic [AW-SL-1:0] susp_sector_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic          rd_stb_i = 1'b0;
  logic [7:0]    array_data_i = '0;
  logic [7:0]    dq_o;

  int checks = 0;
  int errors = 0;
  logic e6, e2;

  always #10 clk = ~clk;

  poll_status_gen #(.ADDR_W(AW), .SECT_LSB(SL)) i_poll_status_gen (
    .clk(clk), .rst(rst), .abort_err_i(abort_err_i), .prog_dq7_i(prog_dq7_i),
    .ers_susp_i(ers_susp_i), .susp_sector_i(susp_sector_i), .rd_addr_i(rd_addr_i),
    .rd_stb_i(rd_stb_i), .array_data_i(array_data_i), .dq_o(dq_o)
  );

  function automatic logic [7:0] expw(input logic d7, input logic t6,
                                      input logic s, input logic t2);
    return {~d7, t6, 1'b0, 1'b0, s, s & t2, 1'b1, 1'b0};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one read: strobe rises at a falling edge, sampled after the next rising edge
  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    rd_addr_i = a;
    rd_stb_i  = 1'b1;
    @(negedge clk);
    v = dq_o;
    rd_stb_i  = 1'b0;
    @(negedge clk);
  endtask

  task automatic enter(input logic d7, input logic s, input logic [AW-SL-1:0] sec);
    prog_dq7_i = d7; ers_susp_i = s; susp_sector_i = sec;
    abort_err_i = 1'b1;
    e6 = 1'b0; e2 = 1'b0;
    idle(2);
  endtask

  task automatic leave();
    abort_err_i = 1'b0;
    idle(2);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", dq_o, 8'h00);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_pass();
    array_data_i = 8'h5A; idle(1);
    check("R2", dq_o, 8'h5A);
    array_data_i = 8'hC3; idle(1);
    check("R2", dq_o, 8'hC3);
  endtask

  task automatic t_fixed();
    logic [7:0] v;
    enter(1'b1, 1'b0, '0);
    array_data_i = 8'hFF; idle(1);
    check("R2 array ignored", dq_o, expw(1'b1, 1'b0, 1'b0, 1'b0));
    check("R5", dq_o & 8'h33, 8'h02);
    check("R6", {7'b0, dq_o[3]}, 8'h00);
    prog_dq7_i = 1'b0; idle(1);
    check("R3", {7'b0, dq_o[7]}, 8'h01);
    leave();
  endtask

  task automatic t_tgl6();
    logic [7:0] v;
    enter(1'b0, 1'b0, '0);
    for (int i = 0; i < 4; i++) begin
      rd(16'h1000 * i[15:0] + 16'h0123, v);
      check("R4", v, expw(1'b0, e6, 1'b0, 1'b0));
      e6 = ~e6;
    end
    leave();
  endtask

  task automatic t_tgl2();
    logic [7:0] v;
    enter(1'b0, 1'b1, 4'd3);
    rd(16'h3ABC, v); check("R7 hit", v, expw(1'b0, e6, 1'b1, e2)); e6 = ~e6; e2 = ~e2;
    rd(16'h5ABC, v); check("R7 miss", v, expw(1'b0, e6, 1'b1, e2)); e6 = ~e6;
    rd(16'h5000, v); check("R7 miss", v, expw(1'b0, e6, 1'b1, e2)); e6 = ~e6;
    rd(16'h3FFF, v); check("R7 hit", v, expw(1'b0, e6, 1'b1, e2)); e6 = ~e6; e2 = ~e2;
    rd(16'h3000, v); check("R7 hit", v, expw(1'b0, e6, 1'b1, e2)); e6 = ~e6; e2 = ~e2;
    check("R6", {7'b0, v[3]}, 8'h01);
    leave();
  endtask

  task automatic t_reentry();
    logic [7:0] v;
    enter(1'b0, 1'b1, 4'd3);
    rd(16'h3000, v); e6 = ~e6; e2 = ~e2;
    leave();
    enter(1'b0, 1'b1, 4'd3);
    rd(16'h3000, v);
    check("R8", v, expw(1'b0, 1'b0, 1'b1, 1'b0));
    leave();
  endtask

  task automatic t_held();
    logic [7:0] v;
    enter(1'b1, 1'b0, '0);
    rd_addr_i = 16'h0000;
    rd_stb_i  = 1'b1;
    idle(4);
    rd_stb_i  = 1'b0;
    idle(1);
    rd(16'h0000, v);
    check("R9", v, expw(1'b1, 1'b1, 1'b0, 1'b0));
    leave();
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    prog_dq7_i = 1'b0; ers_susp_i = 1'b1; susp_sector_i = 4'd7;
    abort_err_i = 1'b1;
    rd(16'h7010, v);
    check("R8 entry+read", v, expw(1'b0, 1'b0, 1'b1, 1'b0));
    rd(16'h7020, v);
    check("R4 R7 both flipped", v, expw(1'b0, 1'b1, 1'b1, 1'b1));
    leave();
  endtask

  initial begin
    idle(3);
    t_reset();
    t_pass();
    t_fixed();
    t_tgl6();
    t_tgl2();
    t_reentry();
    t_held();
    t_same_cycle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule